// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers interrupt requests from a set of priority levels. Each level owns a vector of individual sources, and a one-bit-per-level status word marks which levels hold at least one pending source. Requests arrive on three synchronous command ports: one sets a single source, one clears a single source, and one empties everything at once. Status and source vectors are the only stored request state.

Every cycle, combinational logic works out a candidate priority and a summary mask. It combines a software request word, whose bits map to offset priorities, with the pending external levels, which stand for themselves. An interrupt request is raised when three conditions hold: the status word is nonzero, the program counter is word aligned, and the candidate beats the current processor priority. When a request is raised, its priority and summary are captured behind a valid flag. A later acknowledge moves the captured pair onto the summary and ID outputs. A read port shows any one level's source vector.

Top module: `irqc_top`

## Requirements
- R1: A post with level n < 32 and source s < NUM_SRC sets bit s of level n's vector (shown on `rd_vec` when `rd_level` = n) and bit n of `lvl_status`, both visible after the next rising edge.
- R2: A clear of level n, source s resets that vector bit; status bit n drops only when the whole level vector becomes zero.
- R3: `clr_all` zeroes every level vector and `lvl_status` in one edge, overriding a post in the same cycle.
- R4: When post and clear name the same level and source in one cycle, the bit ends up cleared.
- R5: A post or clear whose level is 32 or more, or whose source is NUM_SRC or more, changes no state.
- R6: Each set `sw_req` bit i with 1 <= i <= 15 gives candidate priority i and sets summary bit i. `sw_req` bit 0 and bits 16..31 contribute nothing.
- R7: While `lvl_status` is nonzero, each set status bit i with 16 <= i <= 30 gives candidate priority i and sets summary bit i. Levels are taken in ascending order, software before external, so the highest hit wins. Status bits 0..15 and 31 add neither priority nor summary.
- R8: `irq` is 1 only if `lvl_status` is nonzero, `pc[1:0]` == 0, `pend_pri` is nonzero and `pend_pri` > `cur_ipl` (strict).
- R9: On an edge where `irq` is 1 and no acknowledge is accepted, the current `pend_pri` and `pend_sum` are captured and `info_valid` becomes 1.
- R10: Reset makes `info_valid`, `isr_out` and `intid_out` zero. An `ack` while `info_valid` is 1 loads the captured summary into `isr_out` and the captured priority into `intid_out`, and clears `info_valid`. An `ack` while `info_valid` is 0 leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post request strobe |
| post_level | input | 6 | Level of the post |
| post_src | input | $clog2(NUM_SRC)+1 | Source index of the post |
| clr_en | input | 1 | Clear request strobe |
| clr_level | input | 6 | Level of the clear |
| clr_src | input | $clog2(NUM_SRC)+1 | Source index of the clear |
| clr_all | input | 1 | Empty all levels |
| sw_req | input | 32 | Software request word |
| cur_ipl | input | 5 | Current processor priority |
| pc | input | PC_W | Instruction address |
| ack | input | 1 | Acknowledge captured interrupt |
| rd_level | input | 5 | Level selected for inspection |
| rd_vec | output | NUM_SRC | Source vector of the selected level |
| lvl_status | output | 32 | Per-level pending status word |
| pend_pri | output | 5 | Candidate priority |
| pend_sum | output | 32 | Candidate summary mask |
| irq | output | 1 | Interrupt request |
| info_valid | output | 1 | Captured pair waiting for acknowledge |
| isr_out | output | 32 | Acknowledged summary |
| intid_out | output | 5 | Acknowledged priority |

## Verification
The hardest case to reach is a software request deciding the outcome. It only counts while the status word is nonzero, yet any external level in 16..30 would outrank every software bit. The stimulus gets there by posting only to level 3, which is below the external range, after an overriding clear-all. That makes the status word nonzero with no external candidate, so software bits 3, 9 and 15 drive the candidate priority alone. The bench also has to show that an acknowledge with no valid capture is ignored. It does this by holding the current priority at 31 and issuing a second acknowledge once the outputs hold a known value. Between the two acknowledges, a higher level is posted, so a wrongly accepted acknowledge would change the outputs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NLVL   = 32;
    localparam int IDX_W  = $clog2(NLVL);
    localparam int LVL_W  = IDX_W + 1;
    localparam int PRI_W  = 5;
    localparam int SW_LO  = 1;
    localparam int SW_HI  = 16;
    localparam int EXT_LO = 16;
    localparam int EXT_HI = 31;

    typedef logic [NLVL-1:0]  lvl_mask_t;
    typedef logic [PRI_W-1:0] pri_t;

    typedef struct packed {
        pri_t      pri;
        lvl_mask_t sum;
    } eval_t;

    function automatic pri_t sw_pri(input int i);
        return pri_t'(i - SW_LO + 1);
    endfunction
endpackage

// File: rtl/irqc_level_store.sv
module irqc_level_store
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int SRC_IDX_W = $clog2(NUM_SRC) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 post_en,
    input  logic [LVL_W-1:0]     post_level,
    input  logic [SRC_IDX_W-1:0] post_src,
    input  logic                 clr_en,
    input  logic [LVL_W-1:0]     clr_level,
    input  logic [SRC_IDX_W-1:0] clr_src,
    input  logic                 clr_all,
    input  logic [IDX_W-1:0]     rd_level,
    output logic [NUM_SRC-1:0]   rd_vec,
    output lvl_mask_t            status
);
    logic post_ok, clr_ok;
    logic [NUM_SRC-1:0] post_bit, clr_bit;
    logic [NUM_SRC-1:0] vec_all [NLVL];

    assign post_ok  = post_en && (post_level < LVL_W'(NLVL)) && (post_src < SRC_IDX_W'(NUM_SRC));
    assign clr_ok   = clr_en && (clr_level < LVL_W'(NLVL)) && (clr_src < SRC_IDX_W'(NUM_SRC));
    assign post_bit = post_ok ? (NUM_SRC'(1) << post_src) : '0;
    assign clr_bit  = clr_ok ? (NUM_SRC'(1) << clr_src) : '0;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic               post_hit, clr_hit, st_q;
        logic [NUM_SRC-1:0] vec_q, vec_nxt;

        assign post_hit = post_ok && (post_level == LVL_W'(g));
        assign clr_hit  = clr_ok && (clr_level == LVL_W'(g));
        // clear mask applied after the post mask: clear wins on the same bit
        assign vec_nxt  = (vec_q | (post_hit ? post_bit : '0)) & ~(clr_hit ? clr_bit : '0);

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                vec_q <= '0;
                st_q  <= 1'b0;
            end else begin
                vec_q <= vec_nxt;
                st_q  <= (st_q | post_hit) & ~(clr_hit && (vec_nxt == '0));
            end
        end

        assign status[g]  = st_q;
        assign vec_all[g] = vec_q;
    end

    assign rd_vec = vec_all[rd_level];
endmodule

// File: rtl/irqc_prio_eval.sv
module irqc_prio_eval
    import irqc_pkg::*;
(
    input  lvl_mask_t  sw_req,
    input  lvl_mask_t  status,
    input  logic [1:0] pc_low,
    input  pri_t       cur_ipl,
    output eval_t      ev,
    output logic       irq
);
    logic any_pend;
    assign any_pend = |status;

    always_comb begin
        ev = '0;
        for (int i = SW_LO; i < SW_HI; i++) begin
            if (sw_req[i]) begin
                ev.pri    = sw_pri(i);
                ev.sum[i] = 1'b1;
            end
        end
        if (any_pend) begin
            for (int i = EXT_LO; i < EXT_HI; i++) begin
                if (status[i]) begin
                    ev.pri    = pri_t'(i);
                    ev.sum[i] = 1'b1;
                end
            end
        end
    end

    assign irq = any_pend && (pc_low == 2'b00) && (ev.pri != '0) && (ev.pri > cur_ipl);
endmodule

// File: rtl/irqc_ack_latch.sv
module irqc_ack_latch
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      irq,
    input  eval_t     ev,
    input  logic      ack,
    output logic      info_valid,
    output lvl_mask_t isr_out,
    output pri_t      intid_out
);
    eval_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            info_valid <= 1'b0;
            isr_out    <= '0;
            intid_out  <= '0;
        end else if (ack && info_valid) begin
            isr_out    <= held.sum;
            intid_out  <= held.pri;
            info_valid <= 1'b0;
        end else if (irq) begin
            held       <= ev;
            info_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PC_W    = 32,
    localparam int SRC_IDX_W = $clog2(NUM_SRC) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 post_en,
    input  logic [LVL_W-1:0]     post_level,
    input  logic [SRC_IDX_W-1:0] post_src,
    input  logic                 clr_en,
    input  logic [LVL_W-1:0]     clr_level,
    input  logic [SRC_IDX_W-1:0] clr_src,
    input  logic                 clr_all,
    input  logic [NLVL-1:0]      sw_req,
    input  logic [PRI_W-1:0]     cur_ipl,
    input  logic [PC_W-1:0]      pc,
    input  logic                 ack,
    input  logic [IDX_W-1:0]     rd_level,
    output logic [NUM_SRC-1:0]   rd_vec,
    output logic [NLVL-1:0]      lvl_status,
    output logic [PRI_W-1:0]     pend_pri,
    output logic [NLVL-1:0]      pend_sum,
    output logic                 irq,
    output logic                 info_valid,
    output logic [NLVL-1:0]      isr_out,
    output logic [PRI_W-1:0]     intid_out
);
    eval_t ev;

    irqc_level_store #(.NUM_SRC(NUM_SRC), .SRC_IDX_W(SRC_IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .post_en(post_en), .post_level(post_level), .post_src(post_src),
        .clr_en(clr_en), .clr_level(clr_level), .clr_src(clr_src),
        .clr_all(clr_all), .rd_level(rd_level), .rd_vec(rd_vec),
        .status(lvl_status)
    );

    irqc_prio_eval u_eval (
        .sw_req(sw_req), .status(lvl_status), .pc_low(pc[1:0]),
        .cur_ipl(cur_ipl), .ev(ev), .irq(irq)
    );

    irqc_ack_latch u_ack (
        .clk(clk), .rst(rst), .irq(irq), .ev(ev), .ack(ack),
        .info_valid(info_valid), .isr_out(isr_out), .intid_out(intid_out)
    );

    assign pend_pri = ev.pri;
    assign pend_sum = ev.sum;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PC_W    = 32,
    localparam int SRC_IDX_W = $clog2(NUM_SRC) + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 post_en,
    input logic [LVL_W-1:0]     post_level,
    input logic [SRC_IDX_W-1:0] post_src,
    input logic                 clr_en,
    input logic                 clr_all,
    input logic [PC_W-1:0]      pc,
    input logic                 ack,
    input logic                 irq,
    input logic                 info_valid,
    input logic [NLVL-1:0]      isr_out,
    input logic [PRI_W-1:0]     intid_out,
    input logic [NLVL-1:0]      lvl_status
);
    logic post_in_range;
    assign post_in_range = (post_level < LVL_W'(NLVL)) && (post_src < SRC_IDX_W'(NUM_SRC));

    p_post_sets_status_r1: assert property (@(posedge clk) disable iff (rst)
        post_en && post_in_range && !clr_en && !clr_all
        |=> lvl_status[$past(post_level[IDX_W-1:0])]);

    p_clear_all_empties_r3: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (lvl_status == '0));

    p_reject_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
        post_en && !post_in_range && !clr_en && !clr_all |=> $stable(lvl_status));

    p_unaligned_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (pc[1:0] != 2'b00) |-> !irq);

    p_raise_captures_r9: assert property (@(posedge clk) disable iff (rst)
        irq && !(ack && info_valid) |=> info_valid);

    p_ack_consumes_r10: assert property (@(posedge clk) disable iff (rst)
        ack && info_valid |=> !info_valid);

    p_ack_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        ack && !info_valid |=> $stable(isr_out) && $stable(intid_out));
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .post_en(post_en), .post_level(post_level),
    .post_src(post_src), .clr_en(clr_en), .clr_all(clr_all), .pc(pc),
    .ack(ack), .irq(irq), .info_valid(info_valid), .isr_out(isr_out),
    .intid_out(intid_out), .lvl_status(lvl_status)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 16;
    localparam int PC_W       = 32;
    localparam int SIW        = $clog2(NUM_SRC) + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            post_en = 1'b0, clr_en = 1'b0, clr_all = 1'b0, ack = 1'b0;
    logic [5:0]      post_level = '0, clr_level = '0;
    logic [SIW-1:0]  post_src = '0, clr_src = '0;
    logic [31:0]     sw_req = '0;
    logic [4:0]      cur_ipl = '0;
    logic [PC_W-1:0] pc = '0;
    logic [4:0]      rd_level = '0;
    logic [NUM_SRC-1:0] rd_vec;
    logic [31:0]     lvl_status, pend_sum, isr_out;
    logic [4:0]      pend_pri, intid_out;
    logic            irq, info_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    irqc_top #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) dut (
        .clk(clk), .rst(rst), .post_en(post_en), .post_level(post_level),
        .post_src(post_src), .clr_en(clr_en), .clr_level(clr_level),
        .clr_src(clr_src), .clr_all(clr_all), .sw_req(sw_req),
        .cur_ipl(cur_ipl), .pc(pc), .ack(ack), .rd_level(rd_level),
        .rd_vec(rd_vec), .lvl_status(lvl_status), .pend_pri(pend_pri),
        .pend_sum(pend_sum), .irq(irq), .info_valid(info_valid),
        .isr_out(isr_out), .intid_out(intid_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] sw;
        logic [4:0]  ipl;
        logic [1:0]  pcl;
        logic [4:0]  pri;
        logic [31:0] sum;
        logic        irq;
    } vec_t;

    // status word holds only level 18 while this table is walked
    localparam vec_t TBL [8] = '{
        '{32'h0,        5'd0,  2'd0, 5'd18, 32'h0004_0000, 1'b1},
        '{32'h20,       5'd0,  2'd0, 5'd18, 32'h0004_0020, 1'b1},
        '{32'h0,        5'd18, 2'd0, 5'd18, 32'h0004_0000, 1'b0},
        '{32'h0,        5'd17, 2'd0, 5'd18, 32'h0004_0000, 1'b1},
        '{32'h0,        5'd0,  2'd1, 5'd18, 32'h0004_0000, 1'b0},
        '{32'h0,        5'd0,  2'd2, 5'd18, 32'h0004_0000, 1'b0},
        '{32'h0001_8001, 5'd0, 2'd0, 5'd18, 32'h0004_8000, 1'b1},
        '{32'h8000,     5'd31, 2'd0, 5'd18, 32'h0004_8000, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_post(input int lvl, input int src);
        post_en = 1'b1; post_level = 6'(lvl); post_src = SIW'(src);
        tick();
        post_en = 1'b0;
    endtask

    task automatic do_clr(input int lvl, input int src);
        clr_en = 1'b1; clr_level = 6'(lvl); clr_src = SIW'(src);
        tick();
        clr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] snap;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R10 reset info_valid", info_valid, 0);
        chk("R10 reset isr_out", isr_out, 0);
        chk("R10 reset intid_out", intid_out, 0);
        chk("R1 reset status", lvl_status, 0);

        // software request alone, status empty: priority computed, no irq
        sw_req = 32'h200; #1;
        chk("R6 sw-only pri", pend_pri, 9);
        chk("R8 no irq with empty status", irq, 0);
        sw_req = '0;

        do_post(18, 2);
        rd_level = 5'd18; #1;
        chk("R1 status after post", lvl_status, 32'h0004_0000);
        chk("R1 vector after post", rd_vec, 16'h0004);

        for (int k = 0; k < 8; k++) begin
            sw_req = TBL[k].sw; cur_ipl = TBL[k].ipl; pc = {30'd0, TBL[k].pcl};
            #1;
            chk($sformatf("R7 table pri %0d", k), pend_pri, TBL[k].pri);
            chk($sformatf("R6 table sum %0d", k), pend_sum, TBL[k].sum);
            chk($sformatf("R8 table irq %0d", k), irq, TBL[k].irq);
        end

        // capture and acknowledge
        sw_req = '0; cur_ipl = 5'd0; pc = '0;
        tick();
        chk("R9 capture valid", info_valid, 1);
        cur_ipl = 5'd31; ack = 1'b1;
        tick();
        ack = 1'b0;
        chk("R10 ack clears valid", info_valid, 0);
        chk("R10 ack isr_out", isr_out, 32'h0004_0000);
        chk("R10 ack intid_out", intid_out, 18);
        do_post(25, 0);
        chk("R7 higher level wins", pend_pri, 25);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        chk("R10 idle ack isr_out kept", isr_out, 32'h0004_0000);
        chk("R10 idle ack intid kept", intid_out, 18);

        // per-source clear
        do_post(20, 1);
        do_post(20, 4);
        do_clr(20, 1);
        rd_level = 5'd20; #1;
        chk("R2 status kept while sources left", lvl_status[20], 1);
        chk("R2 vector after one clear", rd_vec, 16'h0010);
        do_clr(20, 4);
        chk("R2 status drops when empty", lvl_status[20], 0);

        // post and clear of the same bit in one cycle
        post_en = 1'b1; post_level = 6'd22; post_src = SIW'(3);
        clr_en = 1'b1; clr_level = 6'd22; clr_src = SIW'(3);
        tick();
        post_en = 1'b0; clr_en = 1'b0;
        rd_level = 5'd22; #1;
        chk("R4 same-bit vector", rd_vec, 0);
        chk("R4 same-bit status", lvl_status[22], 0);

        // out-of-range requests
        snap = lvl_status;
        do_post(32, 0);
        chk("R5 bad level status", lvl_status, snap);
        do_post(21, 16);
        rd_level = 5'd21; #1;
        chk("R5 bad source status", lvl_status, snap);
        chk("R5 bad source vector", rd_vec, 0);
        do_clr(18, 16);
        chk("R5 bad clear source", lvl_status, snap);

        // clear-all overrides a same-cycle post
        post_en = 1'b1; post_level = 6'd24; post_src = SIW'(0); clr_all = 1'b1;
        tick();
        post_en = 1'b0; clr_all = 1'b0;
        chk("R3 clear-all status", lvl_status, 0);
        rd_level = 5'd18; #1;
        chk("R3 clear-all vector", rd_vec, 0);

        // software decides: only level 3 pending
        do_post(3, 0);
        sw_req = 32'h208; cur_ipl = 5'd8; pc = 32'h100; #1;
        chk("R6 sw pri", pend_pri, 9);
        chk("R7 low level adds no summary", pend_sum, 32'h208);
        chk("R8 sw irq above ipl", irq, 1);
        cur_ipl = 5'd9; #1;
        chk("R8 strict compare", irq, 0);
        sw_req = 32'h8000; cur_ipl = 5'd0; #1;
        chk("R6 top sw bit", pend_pri, 15);

        // level 31 is outside the external range
        sw_req = '0; clr_all = 1'b1; tick(); clr_all = 1'b0;
        do_post(31, 0);
        chk("R7 level 31 no pri", pend_pri, 0);
        chk("R8 level 31 no irq", irq, 0);

        finish_run();
    end
endmodule